// File: doc/BRIEF.md
# Page Table Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address using a single-level page table kept in memory. A requester presents the virtual address together with a write flag and a supervisor-mode flag. The block adds the virtual page number to a table base input to form the entry address, fetches that entry over a request/response memory port, and judges it. It then returns one of three results: the physical address, a page fault, or a protection fault.

Pages are 64 bytes, so the low six address bits pass through unchanged as the page offset. Bits 13:6 of the virtual address form an 8-bit page number that selects one of 256 table entries. Only one translation is in flight at a time. The request side, the memory request side and the result side each use a ready/valid handshake.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The entry address on `mem_addr` equals `ptbase` (sampled when the request is accepted) plus the page number `req_va[13:6]`, modulo 2^12. It stays stable while `mem_req_valid` is high and `mem_req_ready` is low.
- R3: An entry is 10 bits: [9] valid, [8] supervisor-only, [7] readable, [6] writable, [5:0] physical page. When an access is valid and permitted, the result has status 2'b00 (ok) and `rsp_pa` = {entry[5:0], `req_va[5:0]`}.
- R4: An entry with valid=0 gives status 2'b01 (page fault) with `rsp_pa` = 0, whatever its permission bits are.
- R5: A write (`req_wr`=1) to a valid entry with writable=0 gives status 2'b10 (protection fault) with `rsp_pa` = 0.
- R6: A user access (`req_sup`=0) to a valid entry with supervisor-only=1 gives status 2'b10. The same access in supervisor mode is allowed.
- R7: A read (`req_wr`=0) of a valid entry with readable=0 gives status 2'b10.
- R8: Only one translation is in flight at a time. `req_ready` is 0 from acceptance until the result is taken, so requests offered during that time are ignored. A result held back by `rsp_ready`=0 keeps `rsp_pa` and `rsp_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_va | input | 14 | Virtual address |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_sup | input | 1 | 1 = supervisor mode |
| ptbase | input | 12 | Page table base entry address |
| mem_req_valid | output | 1 | Entry fetch requested |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_addr | output | 12 | Entry address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 10 | Page table entry |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 12 | Physical address (0 on a fault) |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |

## Verification
The hardest case to reach from the ports is a busy unit that is offered a second, different request while the memory side stalls and the result side applies backpressure. Ignoring that request depends on `req_ready` staying low through every phase. The bench keeps `req_valid` asserted with a complemented address for the whole translation. It delays `mem_req_ready` and the entry data by several cycles and holds `rsp_ready` low. It then checks that the result and the fetched address still belong to the first request. Base-plus-page wraparound is reached by choosing a base near the top of the entry address space.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 14;
    localparam int OFF_W  = 6;
    localparam int PPN_W  = 6;
    localparam int TBL_AW = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int PTE_W  = PPN_W + 4;

    typedef struct packed {
        logic             valid;
        logic             sup_only;
        logic             can_rd;
        logic             can_wr;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [1:0] {
        XS_OK    = 2'b00,
        XS_PAGE  = 2'b01,
        XS_PROT  = 2'b10
    } xl_status_e;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic            wr;
        logic            sup;
    } xl_req_t;

    function automatic xl_status_e judge(input pte_t p, input logic wr, input logic sup);
        if (!p.valid)               return XS_PAGE;
        if (p.sup_only && !sup)     return XS_PROT;
        if (wr && !p.can_wr)        return XS_PROT;
        if (!wr && !p.can_rd)       return XS_PROT;
        return XS_OK;
    endfunction
endpackage

// File: rtl/ptw_check.sv
module ptw_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte_raw,
    input  logic             acc_wr,
    input  logic             acc_sup,
    input  logic [OFF_W-1:0] offset,
    output xl_status_e       verdict,
    output logic [PA_W-1:0]  pa
);
    pte_t pte;
    assign pte = pte_t'(pte_raw);

    always_comb begin
        verdict = judge(pte, acc_wr, acc_sup);
        pa      = (verdict == XS_OK) ? {pte.ppn, offset} : '0;
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic fetch_ready,
    input  logic data_valid,
    input  logic out_ready,
    output logic idle,
    output logic fetching,
    output logic done,
    output logic take_req,
    output logic take_pte
);
    typedef enum logic [1:0] {C_IDLE, C_FETCH, C_WAIT, C_DONE} ctrl_e;
    ctrl_e cur, nxt;

    always_ff @(posedge clk) begin
        if (rst) cur <= C_IDLE;
        else     cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            C_IDLE:  if (in_valid)    nxt = C_FETCH;
            C_FETCH: if (fetch_ready) nxt = C_WAIT;
            C_WAIT:  if (data_valid)  nxt = C_DONE;
            C_DONE:  if (out_ready)   nxt = C_IDLE;
            default:                  nxt = C_IDLE;
        endcase
    end

    assign idle     = (cur == C_IDLE);
    assign fetching = (cur == C_FETCH);
    assign done     = (cur == C_DONE);
    assign take_req = idle && in_valid;
    assign take_pte = (cur == C_WAIT) && data_valid;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_wr,
    input  logic              req_sup,
    input  logic [TBL_AW-1:0] ptbase,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [TBL_AW-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_status
);
    xl_req_t           req_q;
    logic [TBL_AW-1:0] base_q;
    logic [PA_W-1:0]   pa_q;
    xl_status_e        st_q;
    logic              take_req, take_pte;
    xl_status_e        chk_st;
    logic [PA_W-1:0]   chk_pa;

    ptw_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (req_valid),
        .fetch_ready (mem_req_ready),
        .data_valid  (mem_rsp_valid),
        .out_ready   (rsp_ready),
        .idle        (req_ready),
        .fetching    (mem_req_valid),
        .done        (rsp_valid),
        .take_req    (take_req),
        .take_pte    (take_pte)
    );

    ptw_check u_check (
        .pte_raw (mem_rsp_data),
        .acc_wr  (req_q.wr),
        .acc_sup (req_q.sup),
        .offset  (req_q.va[OFF_W-1:0]),
        .verdict (chk_st),
        .pa      (chk_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            base_q <= '0;
            pa_q   <= '0;
            st_q   <= XS_OK;
        end else begin
            if (take_req) begin
                req_q  <= '{va: req_va, wr: req_wr, sup: req_sup};
                base_q <= ptbase;
            end
            if (take_pte) begin
                pa_q <= chk_pa;
                st_q <= chk_st;
            end
        end
    end

    assign mem_addr   = base_q + {{(TBL_AW-VPN_W){1'b0}}, req_q.va[VA_W-1:OFF_W]};
    assign rsp_pa     = pa_q;
    assign rsp_status = st_q;
endmodule

// File: rtl/ptw_sva.sv
module ptw_sva
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_va,
    input logic [TBL_AW-1:0] ptbase,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [TBL_AW-1:0] mem_addr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [PA_W-1:0]   rsp_pa,
    input logic [1:0]        rsp_status
);
    logic [VA_W-1:0]   va_seen;
    logic [TBL_AW-1:0] base_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_seen   <= '0;
            base_seen <= '0;
        end else if (req_valid && req_ready) begin
            va_seen   <= req_va;
            base_seen <= ptbase;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> req_ready && !mem_req_valid && !rsp_valid);

    assert_addr_sum_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_addr == base_seen + {{(TBL_AW-VPN_W){1'b0}}, va_seen[VA_W-1:OFF_W]});

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_status == 2'b00 |-> rsp_pa[OFF_W-1:0] == va_seen[OFF_W-1:0]);

    assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_status != 2'b00 |-> rsp_pa == '0);

    assert_status_legal_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_status != 2'b11);

    assert_single_flight_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    assert_phase_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, mem_req_valid, rsp_valid}));

    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_status));
endmodule

bind ptw_top ptw_sva u_sva (.*);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid = 0, req_ready;
    logic [13:0] req_va = '0;
    logic        req_wr = 0, req_sup = 0;
    logic [11:0] ptbase = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [11:0] mem_addr;
    logic        mem_rsp_valid;
    logic [9:0]  mem_rsp_data;
    logic        rsp_valid, rsp_ready = 0;
    logic [11:0] rsp_pa;
    logic [1:0]  rsp_status;

    int nchk = 0, nfail = 0;
    int mem_stall = 0, mem_lat = 0;
    logic [11:0] last_addr;
    logic [9:0]  pmem [0:4095];
    bit finished = 0;

    always #2.5 clk = ~clk;

    ptw_top dut (.*);

    task automatic check(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // memory model
    initial begin
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0; last_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (mem_req_valid) begin
                repeat (mem_stall) @(negedge clk);
                last_addr = mem_addr;
                mem_req_ready = 1;
                @(negedge clk);
                mem_req_ready = 0;
                repeat (mem_lat) @(negedge clk);
                mem_rsp_data  = pmem[last_addr];
                mem_rsp_valid = 1;
            end
        end
    end

    function automatic logic [1:0] exp_st(input logic [9:0] p, input bit wr, input bit sup);
        if (!p[9])         return 2'b01;
        if (p[8] && !sup)  return 2'b10;
        if (wr && !p[6])   return 2'b10;
        if (!wr && !p[7])  return 2'b10;
        return 2'b00;
    endfunction

    // one translation with expectation checks
    task automatic xlate(input string rq, input logic [11:0] base, input logic [7:0] vpn,
                         input logic [5:0] off, input logic [9:0] pte, input bit wr,
                         input bit sup, input int hold);
        logic [13:0] va = {vpn, off};
        logic [11:0] eaddr = base + {4'b0, vpn};
        logic [1:0]  est = exp_st(pte, wr, sup);
        logic [11:0] epa = (est == 2'b00) ? {pte[5:0], off} : 12'h000;
        logic [11:0] pa0;
        logic [1:0]  st0;
        pmem[eaddr] = pte;
        @(negedge clk);
        ptbase = base; req_va = va; req_wr = wr; req_sup = sup; req_valid = 1;
        @(negedge clk);
        // R8: busy after acceptance; keep offering a different request
        check(req_ready == 1'b0, "R8 busy", {15'b0, req_ready}, 16'h0);
        req_va = ~va; req_wr = ~wr; ptbase = ~base;
        while (!rsp_valid) @(negedge clk);
        pa0 = rsp_pa; st0 = rsp_status;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_pa == pa0 && rsp_status == st0, "R8 hold",
                  {rsp_status, 2'b0, rsp_pa}, {st0, 2'b0, pa0});
        end
        check(last_addr == eaddr, "R2 addr", {4'b0, last_addr}, {4'b0, eaddr});
        check(rsp_status == est, rq, {14'b0, rsp_status}, {14'b0, est});
        check(rsp_pa == epa, rq, {4'b0, rsp_pa}, {4'b0, epa});
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0; req_valid = 0;
        check(req_ready == 1'b1, "R8 ready again", {15'b0, req_ready}, 16'h1);
    endtask

    task automatic t_reset;
        check(req_ready == 1 && !mem_req_valid && !rsp_valid, "R1 reset",
              {13'b0, req_ready, mem_req_valid, rsp_valid}, 16'h4);
    endtask

    task automatic t_ok;
        xlate("R3 user read", 12'h100, 8'h0F, 6'h14, 10'b1010_001101, 0, 0, 0);
        xlate("R3 write ok",  12'h100, 8'h2E, 6'h0F, 10'b1011_111010, 1, 0, 0);
    endtask

    task automatic t_invalid;
        xlate("R4 invalid", 12'h200, 8'h03, 6'h21, 10'b0111_010101, 0, 1, 0);
        xlate("R4 invalid beats prot", 12'h200, 8'h04, 6'h01, 10'b0100_000111, 1, 0, 0);
    endtask

    task automatic t_prot;
        xlate("R5 write ro",   12'h040, 8'h10, 6'h3F, 10'b1010_000001, 1, 1, 0);
        xlate("R6 user sup",   12'h040, 8'h11, 6'h05, 10'b1111_000010, 0, 0, 0);
        xlate("R6 sup on sup", 12'h040, 8'h12, 6'h06, 10'b1111_100010, 1, 1, 0);
        xlate("R7 read noread",12'h040, 8'h13, 6'h07, 10'b1001_000011, 0, 1, 0);
    endtask

    task automatic t_wrap;
        xlate("R2 wrap", 12'hFF0, 8'h20, 6'h2A, 10'b1010_110011, 0, 0, 0);
        xlate("R3 top page", 12'h000, 8'hFF, 6'h3F, 10'b1010_111111, 0, 0, 0);
    endtask

    task automatic t_stall;
        mem_stall = 3; mem_lat = 2;
        xlate("R8 stalled", 12'h321, 8'h5A, 6'h11, 10'b1011_011100, 1, 0, 4);
        mem_stall = 0; mem_lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) pmem[i] = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ok();
        t_invalid();
        t_prot();
        t_wrap();
        t_stall();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule